// File: doc/BRIEF.md
# Oversampled Manchester Line Decoder

This block turns a Manchester-coded serial receive line into a stream of decoded bits. The line is sampled once per pulse of a sample enable that runs at eight times the bit rate. The decoder measures how long the line stays at each level, counted in samples. From those lengths it tells the transition in the middle of each bit cell apart from the transitions at cell boundaries. It re-aligns its bit phase on every accepted mid-cell transition. Each decoded bit comes out with a one-clock strobe.

Waveform faults raise a one-clock code-violation pulse and drop the decoder out of lock. A fault is a pulse narrower than the jitter tolerance, a low level that outlasts the bit window, or a transition arriving too late. A line that stays high for two bit times is reported as idle. After idle or a violation, the decoder locks again on the first mid-cell transition it can identify.

Top module: `mdec_rx_decoder`

## Requirements
- R1: The receive line is passed through a two-flop synchronizer and takes effect only at clock edges where `sample_en_i` is high. Changes of `rx_i` while `sample_en_i` stays low produce no strobe, no violation and no change of `line_idle_o`.
- R2: While locked, a transition 6 to 10 samples after the previous accepted mid-cell transition is accepted as the next mid-cell transition. Each accepted mid-cell transition yields exactly one bit and restarts the bit-phase count.
- R3: The decoded bit is the line level after the mid-cell transition: rising gives 1 and falling gives 0. `bit_valid_o` is high for exactly one clock per bit, and `bit_o` holds that bit.
- R4: Half-bit levels lasting 3, 4 or 5 samples are all accepted, so a stream whose halves vary within that range decodes without error.
- R5: A level that lasts only 1 or 2 samples before the next transition raises `code_viol_o` for one clock and drops lock.
- R6: `line_idle_o` rises once the line has been high for 16 consecutive samples (two bit times). It clears at the next transition. No bit is emitted while it is high.
- R7: While locked, a transition 3 to 5 samples after a mid-cell transition is a cell-boundary transition. It does not produce a bit and does not change the decoded value.
- R8: While locked, a low level held beyond the bit window raises `code_viol_o` and drops lock. The window is more than 10 samples after the last mid-cell transition, or more than 5 samples after a boundary transition. A transition more than 10 samples after the last mid-cell transition also raises `code_viol_o` and drops lock.
- R9: While unlocked, only a transition that ends a level of 6 to 10 samples is taken as mid-cell. It locks the decoder and emits its bit. Starting from idle, the first bit of a "1,0" preamble is therefore not emitted and the "0" is.
- R10: While `rst_ni` is low, `bit_valid_o` and `code_viol_o` are 0 and `line_idle_o` is 1.
- R11: A high level after the last bit of a frame does not raise `code_viol_o`, whatever value that bit had.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_en_i | input | 1 | One-clock pulse at eight times the bit rate |
| rx_i | input | 1 | Manchester-coded receive line |
| bit_o | output | 1 | Decoded bit, valid with the strobe |
| bit_valid_o | output | 1 | One-clock strobe per decoded bit |
| code_viol_o | output | 1 | One-clock pulse on a waveform fault |
| line_idle_o | output | 1 | Line has been high for two or more bit times |

## Verification
The assertions check on every cycle that:
- a bit strobe never coincides with a violation or with the idle flag;
- the strobe lasts a single clock;
- idle only rises after a high sample;
- while lock is held, consecutive strobes are between 6 and 10 sample ticks apart.

Only the bench scenarios can show the rest. These cover:
- decoded values across bit patterns and half-bit jitter;
- the dropped first preamble bit on acquisition;
- narrow-pulse, stuck-low and late-edge violations;
- the absence of false violations at the end of a frame.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_MID,   // accepted mid-cell transition
    ACT_BND,   // cell-boundary transition
    ACT_VIOL,  // waveform fault
    ACT_IDLE   // idle threshold reached
  } mdec_act_e;
endpackage

// File: rtl/mdec_sampler.sv
module mdec_sampler #(
  parameter int SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_en_i,
  input  logic rx_i,
  output logic lvl_o,
  output logic tick_o,
  output logic edge_o
);
  logic [SYNC-1:0] sync_q;
  logic            rx_s;
  logic            lvl_q, tick_q, edge_q;

  assign rx_s = sync_q[SYNC-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      lvl_q  <= 1'b1;
      tick_q <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], rx_i};
      tick_q <= sample_en_i;
      edge_q <= sample_en_i && (rx_s != lvl_q);
      if (sample_en_i) lvl_q <= rx_s;
    end
  end

  assign lvl_o  = lvl_q;
  assign tick_o = tick_q;
  assign edge_o = edge_q;
endmodule

// File: rtl/mdec_sat_cnt.sv
module mdec_sat_cnt #(
  parameter int W   = 5,
  parameter int MAX = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         restart_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= W'(MAX);
    else if (step_i) begin
      if (restart_i)        cnt_q <= W'(1);
      else if (cnt_q != W'(MAX)) cnt_q <= cnt_q + W'(1);
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/mdec_classify.sv
module mdec_classify
  import mdec_pkg::*;
#(
  parameter int HALF_MIN = 3,
  parameter int HALF_MAX = 5,
  parameter int FULL_MIN = 6,
  parameter int FULL_MAX = 10,
  parameter int IDLE_SMP = 16,
  parameter int CW       = 5
) (
  input  logic          tick_i,
  input  logic          edge_i,
  input  logic          lvl_i,
  input  logic          locked_i,
  input  logic          bnd_i,
  input  logic          idle_i,
  input  logic [CW-1:0] run_i,
  input  logic [CW-1:0] phase_i,
  output mdec_act_e     act_o
);
  logic run_narrow, run_full, ph_full, ph_half, low_late;

  assign run_narrow = run_i < CW'(HALF_MIN);
  assign run_full   = (run_i >= CW'(FULL_MIN)) && (run_i <= CW'(FULL_MAX));
  assign ph_full    = (phase_i >= CW'(FULL_MIN)) && (phase_i <= CW'(FULL_MAX));
  assign ph_half    = (phase_i >= CW'(HALF_MIN)) && (phase_i <= CW'(HALF_MAX));
  // next sample would pass the window without the expected mid-cell edge
  assign low_late   = (phase_i >= CW'(FULL_MAX)) || (bnd_i && run_i >= CW'(HALF_MAX));

  always_comb begin
    act_o = ACT_NONE;
    if (tick_i) begin
      if (edge_i) begin
        if (run_narrow)     act_o = ACT_VIOL;
        else if (!locked_i) act_o = run_full ? ACT_MID : ACT_NONE;
        else if (ph_full)   act_o = ACT_MID;
        else if (ph_half && !bnd_i) act_o = ACT_BND;
        else                act_o = ACT_VIOL;
      end else if (lvl_i) begin
        if (!idle_i && run_i == CW'(IDLE_SMP - 1)) act_o = ACT_IDLE;
      end else if (locked_i && low_late) begin
        act_o = ACT_VIOL;
      end
    end
  end
endmodule

// File: rtl/mdec_rx_decoder.sv
module mdec_rx_decoder
  import mdec_pkg::*;
#(
  parameter int OVS       = 8,
  parameter int HALF_MIN  = 3,
  parameter int HALF_MAX  = 5,
  parameter int IDLE_BITS = 2,
  parameter int SYNC      = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_en_i,
  input  logic rx_i,
  output logic bit_o,
  output logic bit_valid_o,
  output logic code_viol_o,
  output logic line_idle_o
);
  localparam int FULL_MIN = 2 * HALF_MIN;
  localparam int FULL_MAX = 2 * HALF_MAX;
  localparam int IDLE_SMP = IDLE_BITS * OVS;
  localparam int CW       = $clog2(IDLE_SMP + 1);

  logic          smp_lvl, smp_tick, smp_edge;
  logic [CW-1:0] run_cnt, phase_cnt;
  logic          locked_q, bnd_q, idle_q, bit_q, valid_q, viol_q;
  mdec_act_e     act;

  mdec_sampler #(.SYNC(SYNC)) u_smp (
    .clk_i, .rst_ni, .sample_en_i, .rx_i,
    .lvl_o(smp_lvl), .tick_o(smp_tick), .edge_o(smp_edge)
  );

  mdec_sat_cnt #(.W(CW), .MAX(IDLE_SMP)) u_run (
    .clk_i, .rst_ni, .step_i(smp_tick), .restart_i(smp_edge), .cnt_o(run_cnt)
  );

  mdec_sat_cnt #(.W(CW), .MAX(IDLE_SMP)) u_phase (
    .clk_i, .rst_ni, .step_i(smp_tick), .restart_i(act == ACT_MID), .cnt_o(phase_cnt)
  );

  mdec_classify #(
    .HALF_MIN(HALF_MIN), .HALF_MAX(HALF_MAX), .FULL_MIN(FULL_MIN),
    .FULL_MAX(FULL_MAX), .IDLE_SMP(IDLE_SMP), .CW(CW)
  ) u_cls (
    .tick_i(smp_tick), .edge_i(smp_edge), .lvl_i(smp_lvl),
    .locked_i(locked_q), .bnd_i(bnd_q), .idle_i(idle_q),
    .run_i(run_cnt), .phase_i(phase_cnt), .act_o(act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      bnd_q    <= 1'b0;
      idle_q   <= 1'b1;
      bit_q    <= 1'b0;
      valid_q  <= 1'b0;
      viol_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      viol_q  <= 1'b0;
      if (smp_tick && smp_edge) idle_q <= 1'b0;
      case (act)
        ACT_MID: begin
          locked_q <= 1'b1;
          bnd_q    <= 1'b0;
          bit_q    <= smp_lvl;
          valid_q  <= 1'b1;
        end
        ACT_BND: bnd_q <= 1'b1;
        ACT_VIOL: begin
          locked_q <= 1'b0;
          bnd_q    <= 1'b0;
          viol_q   <= 1'b1;
        end
        ACT_IDLE: begin
          idle_q   <= 1'b1;
          locked_q <= 1'b0;
          bnd_q    <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign bit_o       = bit_q;
  assign bit_valid_o = valid_q;
  assign code_viol_o = viol_q;
  assign line_idle_o = idle_q;
endmodule

// File: rtl/mdec_checker.sv
module mdec_checker #(
  parameter int HALF_MIN = 3,
  parameter int HALF_MAX = 5
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic lvl_i,
  input logic bit_valid_i,
  input logic code_viol_i,
  input logic line_idle_i
);
  localparam int FULL_MIN = 2 * HALF_MIN;
  localparam int FULL_MAX = 2 * HALF_MAX;

  logic [7:0] gap_q;
  logic       armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q   <= '0;
      armed_q <= 1'b0;
    end else if (bit_valid_i) begin
      gap_q   <= tick_i ? 8'd1 : 8'd0;
      armed_q <= 1'b1;
    end else begin
      if (tick_i && gap_q != 8'hFF) gap_q <= gap_q + 8'd1;
      if (code_viol_i || line_idle_i) armed_q <= 1'b0;
    end
  end

  a_r3_valid_viol_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bit_valid_i, code_viol_i}));

  a_r3_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_i |=> !bit_valid_i);

  a_r6_no_valid_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_i |-> !line_idle_i);

  a_r6_idle_after_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_idle_i) |-> $past(lvl_i));

  a_r2_mid_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_i && armed_q) |-> (gap_q >= 8'(FULL_MIN) && gap_q <= 8'(FULL_MAX)));
endmodule

bind mdec_rx_decoder mdec_checker #(.HALF_MIN(HALF_MIN), .HALF_MAX(HALF_MAX)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(smp_tick), .lvl_i(smp_lvl),
  .bit_valid_i(bit_valid_o), .code_viol_i(code_viol_o), .line_idle_i(line_idle_o)
);

// File: tb/mdec_rx_decoder_tb.sv
module mdec_rx_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {data, first-half samples, second-half samples}
  localparam logic [13:0] VEC [NVEC] = '{
    {8'hA5, 3'd4, 3'd4},
    {8'h00, 3'd4, 3'd4},
    {8'hFF, 3'd3, 3'd5},
    {8'h3C, 3'd5, 3'd3},
    {8'h96, 3'd3, 3'd3},
    {8'h69, 3'd5, 3'd5}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sample_en = 1'b0;
  logic rx = 1'b1;
  logic bit_o, bit_valid, code_viol, line_idle;

  int checks = 0;
  int errors = 0;
  int nv = 0;
  int nviol = 0;
  logic [31:0] hist = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdec_rx_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sample_en_i(sample_en), .rx_i(rx),
    .bit_o(bit_o), .bit_valid_o(bit_valid), .code_viol_o(code_viol), .line_idle_o(line_idle)
  );

  always @(negedge clk) begin
    if (bit_valid) begin
      if (nv < 32) hist[nv] = bit_o;
      nv = nv + 1;
    end
    if (code_viol) nviol = nviol + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    nv = 0; nviol = 0; hist = '0;
  endtask

  // one enabled sample at the given level
  task automatic samp(input logic lvl);
    rx = lvl;
    repeat (3) @(negedge clk);
    sample_en = 1'b1;
    @(negedge clk);
    sample_en = 1'b0;
  endtask

  task automatic run(input logic lvl, input int n);
    for (int i = 0; i < n; i++) samp(lvl);
  endtask

  task automatic mbit(input logic b, input int h1, input int h2);
    run(~b, h1);
    run(b, h2);
  endtask

  task automatic preamble();
    mbit(1'b1, 4, 4);
    mbit(1'b0, 4, 4);
  endtask

  task automatic settle();
    run(1'b1, 20);
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(bit_valid == 1'b0, "R10 valid in reset", bit_valid, 0);
    chk(code_viol == 1'b0, "R10 viol in reset", code_viol, 0);
    chk(line_idle == 1'b1, "R10 idle in reset", line_idle, 1);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: line activity without sample enable is invisible
    clr_mon();
    for (int i = 0; i < 40; i++) begin
      rx = i[0];
      @(negedge clk);
    end
    rx = 1'b1;
    repeat (4) @(negedge clk);
    chk(nv == 0 && nviol == 0, "R1 no output without enable", nv + nviol, 0);
    chk(line_idle == 1'b1, "R1 idle unchanged", line_idle, 1);

    // table of frames: R2 R3 R4 R7 R9 R11
    for (int k = 0; k < NVEC; k++) begin
      logic [7:0] d;
      int h1, h2;
      d  = VEC[k][13:6];
      h1 = int'(VEC[k][5:3]);
      h2 = int'(VEC[k][2:0]);
      clr_mon();
      preamble();
      for (int i = 0; i < 8; i++) mbit(d[i], h1, h2);
      settle();
      chk(nv == 9, "R9 bits emitted after acquisition", nv, 9);
      chk(hist[0] == 1'b0 && hist[8:1] == d, "R3 R4 R7 decoded data", hist[8:0], {d, 1'b0});
      chk(nviol == 0, "R11 no violation on frame", nviol, 0);
    end

    // R6: idle clears on transition and returns after two bit times high
    clr_mon();
    preamble();
    repeat (4) @(negedge clk);
    chk(line_idle == 1'b0, "R6 idle cleared by activity", line_idle, 0);
    settle();
    chk(line_idle == 1'b1, "R6 idle after 16 high samples", line_idle, 1);

    // R5: narrow low pulse from idle
    clr_mon();
    run(1'b0, 2);
    settle();
    chk(nviol == 1, "R5 narrow pulse flagged", nviol, 1);
    chk(nv == 0, "R5 no bit from narrow pulse", nv, 0);

    // R8: low held past the window after lock
    clr_mon();
    preamble();
    run(1'b0, 12);
    settle();
    chk(nviol == 1, "R8 stuck low flagged", nviol, 1);
    chk(nv == 1, "R8 bits before stuck low", nv, 1);

    // R8: transition later than the window while high
    clr_mon();
    preamble();
    run(1'b0, 4);
    run(1'b1, 12);
    run(1'b0, 4);
    settle();
    chk(nviol == 1, "R8 late transition flagged", nviol, 1);
    chk(nv == 2 && hist[1:0] == 2'b10, "R8 bits before late transition", hist[1:0], 2);

    summary();
    $finish;
  end
endmodule